// File: doc/BRIEF.md
# Stochastic Leaky Integrate-and-Fire Neuron

This block is one digital spiking neuron. It has `N_SYN` binary synapse inputs. Each integration step is started by a pulse on `step_start`. The neuron then walks through its synapses one per clock and adds the stored signed weight of every synapse that was active when the step began. At the end of the step it updates a 16-bit signed membrane potential. The new potential is the old one, shrunk by a shift-based forgetting factor on leak steps, plus the summed weights, plus a bias, saturated to the signed range. The neuron then decides whether to fire.

There are four firing modes:
- a stochastic mode, which compares the potential against a pseudo-random number and so gives a sigmoid-like firing rate;
- a threshold mode that reloads the potential with a configurable value after a spike;
- a threshold mode that subtracts the threshold after a spike;
- a silent mode that only integrates.

Weights and all settings are written through a single-cycle register-write port. The threshold may be changed between steps while the neuron runs.

Top module: `spk_neuron`

## Requirements
- R1: After reset `y_out` is 0 and `spike_out` and `step_done` are low. The register defaults are: all weights 0, bias 0, leak shift 0 (leak off), LF 0, LP 0, mode 1, threshold 0x4000 and reload value 0.
- R2: A write with `cfg_we` high stores `cfg_wdata` at the next edge, according to this map:
  - addresses 0..N_SYN-1 hold the synapse weights (signed, bits [7:0]);
  - address N_SYN holds the bias (signed 16-bit);
  - address N_SYN+1 holds the leak settings: shift k in bits [2:0], LF in bits [5:3], LP in bits [9:6];
  - address N_SYN+2 holds the mode in bits [1:0];
  - address N_SYN+3 holds the threshold (signed 16-bit);
  - address N_SYN+4 holds the reload value (signed 16-bit).

  Writes to any other address change nothing.
- R3: `spk_in` is captured on the edge where `step_start` is seen while the neuron is idle. `step_done` and the new `y_out` appear after edge N_SYN+1 counted from that capture edge. `y_out` changes at no other time. A `step_start` that arrives while a step is in progress is ignored.
- R4: The new potential is Y' = sat(Yl + sum of weights of the captured active synapses + bias), where sat clamps to [-32768, 32767].
- R5: On a leak step with k ≠ 0, Yl = Y − (Y >>> k) (arithmetic shift). Otherwise Yl = Y. Leak steps are defined by a step counter. The counter is cleared by reset or by a write to the leak register. The counter's period is (LP+1)·2^LF steps, so the first leak step is step number (LP+1)·2^LF after the clear.
- R6: In mode 0 the neuron fires when Y' > R, where R is the current 16-bit generator value read as signed. Y becomes Y'. The generator:
  - is seeded with 0xACE1;
  - advances once at the end of every step, after it has been used;
  - shifts left, with bit0 taking b15^b13^b12^b10.
- R7: In mode 1 the neuron fires when Y' ≥ threshold. On a spike Y becomes the reload value; without a spike Y becomes Y'.
- R8: In mode 2 the neuron fires when Y' ≥ threshold. On a spike Y becomes sat(Y' − threshold); without a spike Y becomes Y'.
- R9: In mode 3 the neuron never fires, and Y becomes Y'.
- R10: `spike_out` and `step_done` are single-cycle pulses. `spike_out` is only ever high in the cycle where `step_done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address |
| cfg_wdata | input | Y_W | Register write data |
| step_start | input | 1 | Starts one integration step when idle |
| spk_in | input | N_SYN | Binary synapse inputs |
| spike_out | output | 1 | Output spike pulse |
| step_done | output | 1 | End-of-step strobe |
| y_out | output | Y_W | Membrane potential |

## Verification
Every result of a step lands in one cycle: `y_out`, `spike_out` and `step_done` are all updated on edge N_SYN+1 after the capture edge. The bench counts falling edges from the start request and expects `step_done` on the (N_SYN+2)-th falling edge. It samples the potential and the spike there, and confirms on the next falling edge that the strobes have dropped. The bench changes `spk_in` right after the capture edge, and it holds `step_start` high into the busy phase. These two tests show that the captured pattern alone decides the step, and that the extra start requests start no second step. A register write takes effect on the edge that follows it, and the step model in the bench is updated at that same point, before the next step is launched.

// File: rtl/spk_pkg.sv
package spk_pkg;

    typedef enum logic [1:0] {
        ACT_RANDOM   = 2'd0,
        ACT_RELOAD   = 2'd1,
        ACT_SUBTRACT = 2'd2,
        ACT_SILENT   = 2'd3
    } act_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ACCUM = 2'd1,
        SEQ_FINAL = 2'd2
    } seq_state_e;

    localparam int unsigned LEAK_K_W = 3;

endpackage

// File: rtl/spk_cfg_regs.sv
module spk_cfg_regs
    import spk_pkg::*;
#(
    parameter int unsigned N_SYN  = 8,
    parameter int unsigned W_W    = 8,
    parameter int unsigned Y_W    = 16,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned LF_W   = 3,
    parameter int unsigned LP_W   = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [Y_W-1:0]              wdata,
    output logic [N_SYN-1:0][W_W-1:0]   weights,
    output logic [Y_W-1:0]              bias,
    output logic [LEAK_K_W-1:0]         leak_k,
    output logic [LF_W-1:0]             leak_lf,
    output logic [LP_W-1:0]             leak_lp,
    output act_mode_e                   mode,
    output logic [Y_W-1:0]              thr,
    output logic [Y_W-1:0]              reload,
    output logic                        leak_wr
);

    localparam int unsigned A_BIAS   = N_SYN;
    localparam int unsigned A_LEAK   = N_SYN + 1;
    localparam int unsigned A_MODE   = N_SYN + 2;
    localparam int unsigned A_THR    = N_SYN + 3;
    localparam int unsigned A_RELOAD = N_SYN + 4;
    localparam int unsigned LF_LSB   = LEAK_K_W;
    localparam int unsigned LP_LSB   = LEAK_K_W + LF_W;

    typedef struct packed {
        logic [N_SYN-1:0][W_W-1:0] w;
        logic [Y_W-1:0]            bias;
        logic [LEAK_K_W-1:0]       k;
        logic [LF_W-1:0]           lf;
        logic [LP_W-1:0]           lp;
        act_mode_e                 mode;
        logic [Y_W-1:0]            thr;
        logic [Y_W-1:0]            reload;
    } regs_t;

    regs_t r_d, r_q;
    logic [N_SYN-1:0] w_sel;

    for (genvar g = 0; g < N_SYN; g++) begin : g_wsel
        assign w_sel[g] = we && (addr == ADDR_W'(g));
    end

    always_comb begin
        r_d = r_q;
        for (int i = 0; i < N_SYN; i++) begin
            if (w_sel[i]) r_d.w[i] = wdata[W_W-1:0];
        end
        if (we) begin
            if (addr == ADDR_W'(A_BIAS))   r_d.bias = wdata;
            if (addr == ADDR_W'(A_LEAK)) begin
                r_d.k  = wdata[LEAK_K_W-1:0];
                r_d.lf = wdata[LF_LSB +: LF_W];
                r_d.lp = wdata[LP_LSB +: LP_W];
            end
            if (addr == ADDR_W'(A_MODE))   r_d.mode   = act_mode_e'(wdata[1:0]);
            if (addr == ADDR_W'(A_THR))    r_d.thr    = wdata;
            if (addr == ADDR_W'(A_RELOAD)) r_d.reload = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.w      <= '0;
            r_q.bias   <= '0;
            r_q.k      <= '0;
            r_q.lf     <= '0;
            r_q.lp     <= '0;
            r_q.mode   <= ACT_RELOAD;
            r_q.thr    <= Y_W'(1 << (Y_W - 2));
            r_q.reload <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign weights = r_q.w;
    assign bias    = r_q.bias;
    assign leak_k  = r_q.k;
    assign leak_lf = r_q.lf;
    assign leak_lp = r_q.lp;
    assign mode    = r_q.mode;
    assign thr     = r_q.thr;
    assign reload  = r_q.reload;
    assign leak_wr = we && (addr == ADDR_W'(A_LEAK));

    // R2
    leak_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        leak_wr |=> (leak_k == $past(wdata[LEAK_K_W-1:0])) && (leak_lp == $past(wdata[LP_LSB +: LP_W])));

endmodule

// File: rtl/spk_leak_timer.sv
module spk_leak_timer #(
    parameter int unsigned LF_W = 3,
    parameter int unsigned LP_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            tick,
    input  logic [LF_W-1:0] lf,
    input  logic [LP_W-1:0] lp,
    output logic            due
);

    localparam int unsigned PER_W = LP_W + (1 << LF_W);

    logic [PER_W-1:0] period;
    logic [PER_W-1:0] cnt_d, cnt_q;

    always_comb begin
        period = (PER_W'(lp) + PER_W'(1)) << lf;
        due    = tick && (cnt_q == period - PER_W'(1));
        cnt_d  = cnt_q;
        if (clear)    cnt_d = '0;
        else if (due) cnt_d = '0;
        else if (tick) cnt_d = cnt_q + PER_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < period);

    // R5
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));

endmodule

// File: rtl/spk_lfsr.sv
module spk_lfsr #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        advance,
    output logic [15:0] value
);

    logic [15:0] lfsr_d, lfsr_q;
    logic        fb;

    always_comb begin
        fb     = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];
        lfsr_d = advance ? {lfsr_q[14:0], fb} : lfsr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign value = lfsr_q;

    // R6
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != 16'h0000);

    // R6
    lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(lfsr_q));

endmodule

// File: rtl/spk_neuron.sv
module spk_neuron
    import spk_pkg::*;
#(
    parameter int unsigned N_SYN  = 8,
    parameter int unsigned W_W    = 8,
    parameter int unsigned Y_W    = 16,
    parameter int unsigned LF_W   = 3,
    parameter int unsigned LP_W   = 4,
    parameter int unsigned ADDR_W = $clog2(N_SYN + 5)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [Y_W-1:0]    cfg_wdata,
    input  logic              step_start,
    input  logic [N_SYN-1:0]  spk_in,
    output logic              spike_out,
    output logic              step_done,
    output logic [Y_W-1:0]    y_out
);

    localparam int unsigned IDX_W  = (N_SYN > 1) ? $clog2(N_SYN) : 1;
    localparam int unsigned SUM_W  = W_W + IDX_W + 1;
    localparam int unsigned WIDE_W = ((Y_W > SUM_W) ? Y_W : SUM_W) + 3;
    localparam logic signed [WIDE_W-1:0] Y_MAX = WIDE_W'((1 << (Y_W - 1)) - 1);
    localparam logic signed [WIDE_W-1:0] Y_MIN = -Y_MAX - WIDE_W'(1);

    typedef struct packed {
        seq_state_e       st;
        logic [IDX_W-1:0] idx;
        logic [N_SYN-1:0] spk;
        logic [SUM_W-1:0] sum;
        logic [Y_W-1:0]   y;
        logic             spike;
        logic             done;
    } core_t;

    function automatic logic signed [WIDE_W-1:0] ext_y(input logic [Y_W-1:0] v);
        return {{(WIDE_W-Y_W){v[Y_W-1]}}, v};
    endfunction

    function automatic logic signed [WIDE_W-1:0] ext_s(input logic [SUM_W-1:0] v);
        return {{(WIDE_W-SUM_W){v[SUM_W-1]}}, v};
    endfunction

    function automatic logic [Y_W-1:0] sat_y(input logic signed [WIDE_W-1:0] v);
        if (v > Y_MAX)      return Y_W'(Y_MAX);
        else if (v < Y_MIN) return Y_W'(Y_MIN);
        else                return v[Y_W-1:0];
    endfunction

    logic [N_SYN-1:0][W_W-1:0] weights;
    logic [Y_W-1:0]            bias, thr, reload;
    logic [LEAK_K_W-1:0]       leak_k;
    logic [LF_W-1:0]           leak_lf;
    logic [LP_W-1:0]           leak_lp;
    act_mode_e                 mode;
    logic                      leak_wr;
    logic                      leak_due;
    logic [15:0]               rnd;
    logic                      fin;

    core_t c_d, c_q;

    spk_cfg_regs #(
        .N_SYN(N_SYN), .W_W(W_W), .Y_W(Y_W), .ADDR_W(ADDR_W),
        .LF_W(LF_W), .LP_W(LP_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .weights(weights), .bias(bias), .leak_k(leak_k), .leak_lf(leak_lf),
        .leak_lp(leak_lp), .mode(mode), .thr(thr), .reload(reload), .leak_wr(leak_wr)
    );

    spk_leak_timer #(.LF_W(LF_W), .LP_W(LP_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(leak_wr), .tick(fin),
        .lf(leak_lf), .lp(leak_lp), .due(leak_due)
    );

    spk_lfsr #(.SEED(16'hACE1)) u_rng (
        .clk(clk), .rst_n(rst_n), .advance(fin), .value(rnd)
    );

    assign fin = (c_q.st == SEQ_FINAL);

    // membrane update datapath
    logic signed [WIDE_W-1:0] y_w, lk_w, tot_w, yn_w, thr_w, rnd_w, diff_w;
    logic [Y_W-1:0]           y_new, y_next;
    logic                     fire;
    logic [W_W-1:0]           w_cur;

    always_comb begin
        y_w    = ext_y(c_q.y);
        lk_w   = (leak_due && (leak_k != '0)) ? (y_w - (y_w >>> leak_k)) : y_w;
        tot_w  = lk_w + ext_s(c_q.sum) + ext_y(bias);
        y_new  = sat_y(tot_w);
        yn_w   = ext_y(y_new);
        thr_w  = ext_y(thr);
        rnd_w  = {{(WIDE_W-16){rnd[15]}}, rnd};
        diff_w = yn_w - thr_w;
        unique case (mode)
            ACT_RANDOM: begin
                fire   = yn_w > rnd_w;
                y_next = y_new;
            end
            ACT_RELOAD: begin
                fire   = yn_w >= thr_w;
                y_next = fire ? reload : y_new;
            end
            ACT_SUBTRACT: begin
                fire   = yn_w >= thr_w;
                y_next = fire ? sat_y(diff_w) : y_new;
            end
            default: begin
                fire   = 1'b0;
                y_next = y_new;
            end
        endcase
    end

    // sequencer
    always_comb begin
        c_d       = c_q;
        c_d.spike = 1'b0;
        c_d.done  = 1'b0;
        w_cur     = weights[c_q.idx];
        unique case (c_q.st)
            SEQ_IDLE: begin
                if (step_start) begin
                    c_d.st  = SEQ_ACCUM;
                    c_d.idx = '0;
                    c_d.spk = spk_in;
                    c_d.sum = '0;
                end
            end
            SEQ_ACCUM: begin
                if (c_q.spk[c_q.idx]) begin
                    c_d.sum = c_q.sum + {{(SUM_W-W_W){w_cur[W_W-1]}}, w_cur};
                end
                if (c_q.idx == IDX_W'(N_SYN - 1)) c_d.st  = SEQ_FINAL;
                else                              c_d.idx = c_q.idx + IDX_W'(1);
            end
            SEQ_FINAL: begin
                c_d.y     = y_next;
                c_d.spike = fire;
                c_d.done  = 1'b1;
                c_d.st    = SEQ_IDLE;
            end
            default: c_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st    <= SEQ_IDLE;
            c_q.idx   <= '0;
            c_q.spk   <= '0;
            c_q.sum   <= '0;
            c_q.y     <= '0;
            c_q.spike <= 1'b0;
            c_q.done  <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign spike_out = c_q.spike;
    assign step_done = c_q.done;
    assign y_out     = c_q.y;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |=> !step_done);

    // R3
    y_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(y_out) |-> step_done);

    // R3
    accum_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == SEQ_ACCUM) |=>
            (c_q.st == SEQ_FINAL) ||
            ((c_q.st == SEQ_ACCUM) && (c_q.idx == $past(c_q.idx) + IDX_W'(1))));

    // R9
    silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && (mode == ACT_SILENT)) |=> !spike_out);

    // R7
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && (mode == ACT_RELOAD)) |=> (!spike_out || (y_out == $past(reload))));

endmodule

// File: tb/spk_neuron_tb_top.sv
module spk_neuron_tb_top;

    localparam int N      = 8;
    localparam int ADDR_W = $clog2(N + 5);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [15:0]       cfg_wdata = '0;
    logic              step_start = 1'b0;
    logic [N-1:0]      spk_in = '0;
    logic              spike_out, step_done;
    logic [15:0]       y_out;

    always #5 clk = ~clk;

    spk_neuron dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .step_start(step_start), .spk_in(spk_in),
        .spike_out(spike_out), .step_done(step_done), .y_out(y_out)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // bench model state
    int cw[N];
    int cb = 0, ck = 0, clf = 0, clp = 0, cmode = 1, cthr = 16384, crst = 0;
    int m_y = 0, m_cnt = 0;
    logic [15:0] m_lfsr = 16'hACE1;

    function automatic int s16(input int d);
        logic [15:0] t;
        t = d[15:0];
        return int'($signed(t));
    endfunction

    function automatic int s8(input int d);
        logic [7:0] t;
        t = d[7:0];
        return int'($signed(t));
    endfunction

    function automatic int sat(input int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        cfg_addr  = ADDR_W'(a);
        cfg_wdata = d[15:0];
        cfg_we    = 1'b1;
        @(negedge clk);
        cfg_we    = 1'b0;
        if (a < N)           cw[a] = s8(d);
        else if (a == N)     cb = s16(d);
        else if (a == N + 1) begin
            ck = d & 7; clf = (d >> 3) & 7; clp = (d >> 6) & 15; m_cnt = 0;
        end
        else if (a == N + 2) cmode = d & 3;
        else if (a == N + 3) cthr = s16(d);
        else if (a == N + 4) crst = s16(d);
    endtask

    // one step: model first, then drive and compare
    task automatic step(input logic [N-1:0] pat, input int hold, input string req);
        int sum, per, ly, yn, r, lat, ey;
        bit due, ef, early;
        logic fb;
        sum = 0;
        for (int i = 0; i < N; i++) if (pat[i]) sum += cw[i];
        per = (clp + 1) << clf;
        due = (m_cnt == per - 1);
        m_cnt = due ? 0 : m_cnt + 1;
        ly = (due && ck != 0) ? (m_y - (m_y >>> ck)) : m_y;
        yn = sat(ly + sum + cb);
        r  = int'($signed(m_lfsr));
        case (cmode)
            0: begin ef = (yn > r);     ey = yn; end
            1: begin ef = (yn >= cthr); ey = ef ? crst : yn; end
            2: begin ef = (yn >= cthr); ey = ef ? sat(yn - cthr) : yn; end
            default: begin ef = 1'b0;   ey = yn; end
        endcase
        m_y = ey;
        fb = m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10];
        m_lfsr = {m_lfsr[14:0], fb};

        spk_in = pat;
        step_start = 1'b1;
        @(negedge clk);
        lat = 1;
        spk_in = ~pat;
        if (hold == 0) step_start = 1'b0;
        early = 1'b0;
        while (!step_done && lat < 40) begin
            if (lat > hold) step_start = 1'b0;
            if (spike_out) early = 1'b1;
            @(negedge clk);
            lat++;
        end
        step_start = 1'b0;
        chk(lat == N + 2, "R3 latency", lat, N + 2);
        chk(!early, "R10 spike before done", int'(early), 0);
        chk(int'($signed(y_out)) == ey, {req, " y"}, int'($signed(y_out)), ey);
        chk(spike_out == ef, {req, " spike"}, int'(spike_out), int'(ef));
        @(negedge clk);
        chk(!step_done && !spike_out, "R10 pulse width", int'(step_done) + int'(spike_out), 0);
    endtask

    initial begin
        for (int i = 0; i < N; i++) cw[i] = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(y_out == 16'd0, "R1 y after reset", int'(y_out), 0);
        chk(!step_done && !spike_out, "R1 strobes after reset", int'(step_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(y_out == 16'd0, "R1 y idle", int'(y_out), 0);
        step(8'hFF, 0, "R1 defaults");

        // R2 weights, silent mode, sweep of every spike pattern (R4, R9)
        wr(0, 25); wr(1, -13); wr(2, 47); wr(3, -128);
        wr(4, 127); wr(5, 1); wr(6, -66); wr(7, 30);
        wr(N + 2, 3);
        for (int p = 0; p < 256; p++) step(p[N-1:0], 0, "R4 R9 pattern");

        // R2 unmapped address ignored
        cfg_addr = ADDR_W'(N + 5); cfg_wdata = 16'h7FFF; cfg_we = 1'b1;
        @(negedge clk); cfg_we = 1'b0;
        step(8'h15, 0, "R2 unmapped write");

        // R4 saturation both ends
        wr(N, 16'h7000);
        for (int i = 0; i < 4; i++) step(8'h10, 0, "R4 saturate high");
        chk(y_out == 16'h7FFF, "R4 clamp high", int'(y_out), 32767);
        wr(N, -16'h7000);
        for (int i = 0; i < 6; i++) step(8'h08, 0, "R4 saturate low");
        chk(y_out == 16'h8000, "R4 clamp low", int'(y_out), 32768);

        // R5 leak sweep over shift and period settings
        for (int k = 1; k < 8; k++)
            for (int lf = 0; lf < 3; lf++)
                for (int lp = 0; lp < 3; lp++) begin
                    wr(N + 1, k | (lf << 3) | (lp << 6));
                    wr(N, (k & 1) ? 12000 : -12000);
                    step(8'h00, 0, "R5 charge");
                    wr(N, 0);
                    for (int s = 0; s < 2 * ((lp + 1) << lf) + 1; s++)
                        step(8'h00, 0, "R5 leak");
                end

        // R7 reload mode with runtime threshold change
        wr(N + 1, 0); wr(N, 7); wr(N + 3, 100); wr(N + 4, -20); wr(N + 2, 1);
        for (int i = 0; i < 50; i++) step(N'((i * 37) & 255), 0, "R7 reload");
        wr(N + 3, 40);
        for (int i = 0; i < 30; i++) step(N'((i * 91) & 255), 0, "R7 new threshold");

        // R8 subtract mode
        wr(N, 9); wr(N + 3, 150); wr(N + 2, 2);
        for (int i = 0; i < 60; i++) step(N'((i * 53 + 7) & 255), 0, "R8 subtract");

        // R3 start held while busy and spikes changed after capture
        step(8'hA5, 3, "R3 busy start");
        step(8'h3C, 5, "R3 busy start");

        // R6 stochastic mode at several bias levels
        wr(N + 1, 1); wr(N + 2, 0);
        for (int b = 0; b < 5; b++) begin
            wr(N, (b - 2) * 9000);
            for (int i = 0; i < 40; i++) step(N'((i * 29 + b) & 255), 0, "R6 stochastic");
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule